// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a single-channel SPI master that a processor drives through three byte-wide registers: configuration, status and data. Storing a byte into the data register launches an 8-bit full-duplex exchange. The byte held in the data register goes out on the serial output. At the same time, the byte arriving on the serial input is assembled and can be read back from the same register address once the exchange is over.

The serial clock is divided down from the system clock. Two rate bits in the configuration register and a double-speed bit in the status register select the divisor. Clock polarity, clock phase and bit order are all programmable. A completion flag reports the end of each byte. Software clears it in two steps: first it reads status while the flag is up, then it touches the data register. A flag left set is carried into the next exchange.

The register port is a plain single-cycle bus, not a stream. Every access completes in the cycle it is presented and there is no back-pressure. Read data follows the address combinationally. Software paces transfers by polling the flag.

Top module: `spim_ctrl`

Register addresses: 0 = configuration, 1 = status, 2 = data. Configuration bits: [7] interrupt enable (stored only), [6] enable, [5] LSB-first, [4] master, [3] CPOL, [2] CPHA, [1:0] rate. Status bits: [7] done flag, [6] collision, [0] double-speed.

## Requirements
- R1: After reset, all three registers read 0x00, the serial clock is low and the serial output is low.
- R2: The divisor, indexed by {double-speed, rate[1:0]}, is: 100→2, 000→4, 101→8, 001→16, 110→32, 010→64, 111→64, 011→128. Each serial clock half-period lasts divisor/2 system clocks.
- R3: The serial clock rests at the CPOL level whenever no exchange is running. An exchange produces exactly 16 clock transitions, the first one half-period after the data write.
- R4: With CPHA=0, the first data bit appears in the cycle after the data write and each later bit changes on a trailing edge. With CPHA=1, each bit changes on a leading edge. Bits leave MSB first when configuration bit 5 is 0, and LSB first when it is 1.
- R5: The input is sampled on leading edges when CPHA=0 and on trailing edges when CPHA=1, in the same bit order as the output. The assembled byte reads back from address 2 after completion.
- R6: The done flag (status bit 7) rises one cycle after the last clock edge of an exchange.
- R7: The done flag and collision bit clear only on a data-register read or write that follows a status read which saw either of them set. A data access with no such status read leaves them set.
- R8: A flag that is never cleared stays set through the following exchange.
- R9: A data write made during an exchange sets the collision bit (status bit 6) and changes neither the serial clock, the serial output nor the received byte.
- R10: With enable at 0, the serial clock holds the CPOL level, the serial output is low and a data write starts nothing. With master at 0, a data write starts nothing.
- R11: A status write changes only the double-speed bit. Bits 7 and 6 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: an 8-bit shift width and a 6-bit half-period counter. That counter reaches every divisor from 2 up to 128, so both the fastest setting, where the clock toggles every system cycle, and the slowest are exercised. A behavioural slave in the bench feeds the input line from its own timing formula. All four clock modes and both bit orders are run, and the serial clock and output are compared cycle by cycle against that formula. The runs include a collision write in mid-exchange, a stale flag carried into a second exchange, and exchanges attempted with enable or master held at 0.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 6;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half-period length minus one, in system clocks
  function automatic logic [HALF_W-1:0] half_m1(input logic dbl, input logic [1:0] rate);
    case ({dbl, rate})
      3'b100:  return HALF_W'(0);
      3'b000:  return HALF_W'(1);
      3'b101:  return HALF_W'(3);
      3'b001:  return HALF_W'(7);
      3'b110:  return HALF_W'(15);
      3'b010:  return HALF_W'(31);
      3'b111:  return HALF_W'(31);
      default: return HALF_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/spim_rate.sv
module spim_rate
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] limit,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || tick)    cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck_act,
  output logic              mosi_q,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int EDGE_W = IDX_W + 1;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*BYTE_W-1);
  localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(BYTE_W-1);

  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] tx_q;
  logic [IDX_W-1:0]  bitn;
  logic              sample_now;

  function automatic logic [IDX_W-1:0] pos(input logic [IDX_W-1:0] idx, input logic lsb);
    return lsb ? idx : (LAST_BIT - idx);
  endfunction

  assign bitn       = edge_q[EDGE_W-1:1];
  assign sample_now = (edge_q[0] == cpha);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck_act <= 1'b0;
      mosi_q  <= 1'b0;
      done    <= 1'b0;
      edge_q  <= '0;
      tx_q    <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy    <= 1'b0;
        sck_act <= 1'b0;
      end else if (start && !busy) begin
        busy    <= 1'b1;
        sck_act <= 1'b0;
        edge_q  <= '0;
        tx_q    <= tx_byte;
        if (!cpha) mosi_q <= tx_byte[pos('0, lsb_first)];
      end else if (busy && tick) begin
        sck_act <= ~sck_act;
        edge_q  <= edge_q + 1'b1;
        if (sample_now) begin
          rx_byte[pos(bitn, lsb_first)] <= miso;
        end else if (cpha) begin
          mosi_q <= tx_q[pos(bitn, lsb_first)];
        end else if (bitn != LAST_BIT) begin
          mosi_q <= tx_q[pos(IDX_W'(bitn + 1'b1), lsb_first)];
        end
        if (edge_q == LAST_EDGE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output ctrl_t             ctrl_q,
  output logic              dbl_q,
  output logic              flag_q,
  output logic              coll_q,
  output logic              armed_q,
  output logic              start
);
  logic data_acc, data_wr, stat_rd;

  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == A_DATA);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign start    = data_wr && !busy && ctrl_q.enable && ctrl_q.master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      flag_q  <= 1'b0;
      coll_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_wr && bus_addr == A_STAT) dbl_q  <= bus_wdata[0];
      if (stat_rd && (flag_q || coll_q)) armed_q <= 1'b1;
      if (data_acc && armed_q) begin
        flag_q  <= 1'b0;
        coll_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (data_wr && busy) coll_q <= 1'b1;
      if (done)            flag_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {flag_q, coll_q, {(BYTE_W-3){1'b0}}, dbl_q};
      A_DATA:  bus_rdata = rx_byte;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  ctrl_t             ctrl_q;
  logic              dbl_q, flag_q, coll_q, armed_q, start;
  logic              busy, sck_act, mosi_q, done, tick;
  logic [BYTE_W-1:0] rx_byte;

  spim_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ctrl_q(ctrl_q),
    .dbl_q(dbl_q), .flag_q(flag_q), .coll_q(coll_q), .armed_q(armed_q),
    .start(start)
  );

  spim_rate u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .limit(half_m1(dbl_q, ctrl_q.rate)), .tick(tick)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable), .start(start),
    .tx_byte(bus_wdata), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
    .tick(tick), .miso(spi_miso), .busy(busy), .sck_act(sck_act),
    .mosi_q(mosi_q), .done(done), .rx_byte(rx_byte)
  );

  assign spi_sck  = ctrl_q.cpol ^ (sck_act & ctrl_q.enable);
  assign spi_mosi = ctrl_q.enable & mosi_q;
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wbit0,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              en,
  input logic              cpol,
  input logic              busy,
  input logic              flag,
  input logic              coll,
  input logic              armed,
  input logic              dbl
);
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (spi_sck == cpol) && !spi_mosi); // R10
  AST_DIS_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sck == cpol); // R3
  AST_FLAG_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(busy) && $past(busy, 2)); // R6
  AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA && busy) |=> coll); // R9
  AST_DS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> dbl == $past(wbit0)); // R11
  AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag); // R7
endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wbit0(bus_wdata[0]), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .en(ctrl_q.enable), .cpol(ctrl_q.cpol), .busy(busy), .flag(flag_q),
  .coll(coll_q), .armed(armed_q), .dbl(dbl_q)
);

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, spi_miso = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       spi_sck, spi_mosi;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spim_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk) d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic int divisor(bit dbl, bit [1:0] rate);
    case ({dbl, rate})
      3'b100: return 2;   3'b000: return 4;
      3'b101: return 8;   3'b001: return 16;
      3'b110: return 32;  3'b010: return 64;
      3'b111: return 64;  default: return 128;
    endcase
  endfunction

  function automatic int bpos(int n, bit lsb);
    return lsb ? n : 7 - n;
  endfunction

  function automatic logic [7:0] cfg(bit cpol, bit cpha, bit lsb, bit [1:0] rate);
    return {2'b01, lsb, 1'b1, cpol, cpha, rate};
  endfunction

  // one exchange, compared every cycle against a timing formula
  task automatic xfer(logic [7:0] c, bit dbl, logic [7:0] tx, logic [7:0] slv,
                      int coll_at, int probe_at, bit clear);
    int h = divisor(dbl, c[1:0]) / 2;
    bit cpol = c[3], cpha = c[2], lsb = c[5];
    logic [7:0] s, d;
    wr(2'd0, c);
    wr(2'd1, {7'b0, dbl});
    wr(2'd2, tx);
    for (int t = 0; t <= 16*h; t++) begin
      int b = cpha ? ((t < h) ? 0 : (t - h) / (2*h)) : t / (2*h);
      if (b > 7) b = 7;
      spi_miso = slv[bpos(b, lsb)];
      if (t == coll_at) begin bus_addr = 2'd2; bus_wdata = ~tx; bus_wr = 1'b1; end
      if (t == probe_at) begin bus_addr = 2'd1; bus_rd = 1'b1; end
      @(negedge clk);
      chk("R2/R3", "sck", spi_sck, ((t < 16*h) ? (t / h) % 2 : 0) ^ cpol);  // R2 R3
      if (!cpha || t >= h) chk("R4", "mosi", spi_mosi, tx[bpos(b, lsb)]);   // R4
      if (t == probe_at) chk("R8", "stale flag", bus_rdata[7], 1);          // R8 and R7
      @(posedge clk); #1 bus_wr = 1'b0; bus_rd = 1'b0;
    end
    if (clear) begin
      rd(2'd1, s);
      chk("R6", "done flag", s[7], 1);                                     // R6
      chk("R9", "collision", s[6], (coll_at >= 0) ? 1 : 0);                // R9
      rd(2'd2, d);
      chk("R5", "rx byte", d, slv);                                        // R5
      rd(2'd1, s);
      chk("R7", "cleared status", s[7:6], 0);                              // R7
    end else begin
      rd(2'd2, d);
      chk("R5", "rx byte", d, slv);                                        // R5
    end
  endtask

  initial begin
    #(4*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", "sck", spi_sck, 0);
    chk("R1", "mosi", spi_mosi, 0);
    rd(2'd0, v); chk("R1", "ctrl", v, 0);
    rd(2'd1, v); chk("R1", "stat", v, 0);
    rd(2'd2, v); chk("R1", "data", v, 0);
    // R11 status writes reach only double-speed
    wr(2'd1, 8'hFE); rd(2'd1, v); chk("R11", "stat after FE", v, 8'h00);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R11", "stat after FF", v, 8'h01);
    // main exchanges over modes, orders and divisors
    xfer(cfg(0, 0, 0, 2'd0), 1'b1, 8'hA5, 8'h3C, -1, -1, 1'b1);
    xfer(cfg(0, 1, 0, 2'd0), 1'b0, 8'h96, 8'hC3, -1, -1, 1'b1);
    xfer(cfg(1, 0, 1, 2'd1), 1'b1, 8'h1E, 8'h81, -1, -1, 1'b1);
    xfer(cfg(1, 1, 1, 2'd1), 1'b0, 8'h7B, 8'hE4, 9, -1, 1'b1);
    xfer(cfg(1, 0, 0, 2'd2), 1'b1, 8'h00, 8'hFF, -1, -1, 1'b1);
    xfer(cfg(0, 1, 1, 2'd2), 1'b0, 8'hD2, 8'h4B, -1, -1, 1'b1);
    xfer(cfg(0, 0, 0, 2'd3), 1'b0, 8'h5A, 8'h69, -1, -1, 1'b0);
    xfer(cfg(1, 1, 0, 2'd3), 1'b1, 8'hC6, 8'h2D, -1, 3, 1'b1);
    // R10 disabled: no activity, mosi low, sck at CPOL
    wr(2'd0, 8'h18);
    wr(2'd2, 8'hFF);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R10", "sck disabled", spi_sck, 1);
      chk("R10", "mosi disabled", spi_mosi, 0);
      @(posedge clk); #1;
    end
    rd(2'd1, v); chk("R10", "no flag when disabled", v[7], 0);
    // R10 master bit clear: no exchange
    wr(2'd0, 8'h41);
    wr(2'd2, 8'hFF);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R10", "sck non-master", spi_sck, 0);
      @(posedge clk); #1;
    end
    rd(2'd1, v); chk("R10", "no flag non-master", v[7], 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule